// File: doc/BRIEF.md
# Multicycle Shared-Unit Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. A single memory port carries both instruction fetches and data accesses, and a single ALU performs address arithmetic, PC increments, branch target computation, comparisons and register-to-register operations. Multiplexers at the inputs of these shared units pick the operands for the current step. Holding registers between steps keep the values that the next step needs: the instruction register, the memory data register, the two operand latches and the ALU result latch.

A separate sequencer drives the select and write-enable pins on every cycle and reads back the opcode, the function field and the ALU zero flag. The memory sits outside the block. It sees the address and write data that the datapath presents, and it returns read data in the same cycle. The memory port is a plain address/data interface with no handshake, because the sequencer alone decides when the memory is read or written. Every input is sampled on the rising edge of `clk`. `rst_n` is an asynchronous active-low reset.

Top module: `mc_datapath`

## Requirements
- R1: Reset sets the PC and every holding register to zero, so with `addr_sel`=0 `mem_addr` reads 0 after reset.
- R2: `mem_addr` is the PC when `addr_sel`=0 and the ALU result latch when `addr_sel`=1.
- R3: The instruction register loads `mem_rdata` on an edge where `ir_we`=1 and otherwise holds. `opcode` is its bits [31:26] and `funct` is its bits [5:0].
- R4: ALU operand one is the PC when `opa_sel`=0 and latch A when `opa_sel`=1. Operand two is chosen by `opb_sel`: 0 gives latch B, 1 gives the constant 4, 2 gives the sign-extended IR[15:0], and 3 gives that value shifted left by two.
- R5: `alu_mode` 0 adds, 1 subtracts (operand one minus operand two), and 2 takes the operation from `funct`. `alu_zero` is high exactly when the live ALU result is zero.
- R6: Under `alu_mode` 2, funct 0x20 adds, 0x22 subtracts, 0x24 is bitwise AND, 0x25 is bitwise OR, and 0x2A gives 1 when operand one is less than operand two as signed numbers and 0 otherwise. Any other funct code adds.
- R7: The PC loads on an edge where `pc_we`=1, or where `pc_we_cond`=1 and `alu_zero`=1. Otherwise it holds.
- R8: The PC source is selected by `pc_src`: 0 gives the live ALU result, 1 gives the ALU result latch, and 2 gives {PC[31:28], IR[25:0], 2'b00}. Code 3 behaves like code 0.
- R9: Register reads use IR[25:21] for latch A and IR[20:16] for latch B. A write with `rf_we`=1 targets IR[20:16] when `wb_dst_sel`=0 and IR[15:11] when `wb_dst_sel`=1. The write data is the ALU result latch when `wb_src_sel`=0 and the memory data register when `wb_src_sel`=1.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: Latches A and B, the memory data register and the ALU result latch load on every edge with no enable. `mem_wdata` is latch B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write qualified by ALU zero |
| pc_src | input | 2 | PC next-value select |
| addr_sel | input | 1 | Memory address select: PC or ALU latch |
| ir_we | input | 1 | Instruction register load enable |
| rf_we | input | 1 | Register file write enable |
| wb_dst_sel | input | 1 | Write-back register select: rt or rd |
| wb_src_sel | input | 1 | Write-back data select: ALU latch or memory data |
| opa_sel | input | 1 | ALU operand one select |
| opb_sel | input | 2 | ALU operand two select |
| alu_mode | input | 2 | ALU control: add, subtract, or by funct |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (latch B) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
Most stimulus is random: the control pins change on every cycle, and memory words sometimes carry one of the five function codes. The bench compares each output with an independent model of the registers. That mix separates operand-select errors from errors in latch timing, because values cross several holding registers before they reach a port. Directed sequences load chosen register values through the memory data path. They then cover the signed compare with a negative operand (a swapped sign shows up), shifted and unshifted immediates with their sign bit set, jumps, and taken and untaken conditional PC writes. They also write to register 0 and then read it back through the ALU.

// File: rtl/mc_datapath_pkg.sv
package mc_datapath_pkg;
  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  localparam logic [1:0] MODE_ADD   = 2'd0;
  localparam logic [1:0] MODE_SUB   = 2'd1;
  localparam logic [1:0] MODE_FUNCT = 2'd2;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [1:0] OPB_REG   = 2'd0;
  localparam logic [1:0] OPB_FOUR  = 2'd1;
  localparam logic [1:0] OPB_IMM   = 2'd2;
  localparam logic [1:0] OPB_IMMSH = 2'd3;

  localparam logic [1:0] PCS_ALU   = 2'd0;
  localparam logic [1:0] PCS_LATCH = 2'd1;
  localparam logic [1:0] PCS_JUMP  = 2'd2;
endpackage

// File: rtl/mc_alu_ctrl.sv
module mc_alu_ctrl
  import mc_datapath_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [5:0] fn,
  output alu_op_e    op
);
  always_comb begin
    op = ALU_ADD;
    case (mode)
      MODE_SUB: op = ALU_SUB;
      MODE_FUNCT: begin
        case (fn)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_datapath_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_SUB: res = x - y;
      ALU_AND: res = x & y;
      ALU_OR:  res = x | y;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      default: res = x + y;
    endcase
  end

  assign zero = (res == '0);

  // the compare result must be a single-bit boolean (R6)
  always_comb begin
    if (op == ALU_SLT) assert_slt_boolean_R6 : assert (res[W-1:1] == '0);
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int N = 1 << AW;

  logic [W-1:0] cells [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cells[i] <= '0;
    end else if (we && wa != '0) begin
      cells[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : cells[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : cells[ra_b];

  // a write to a nonzero register is visible on the next read of that address (R9)
  assert_write_visible_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> (ra_a != $past(wa)) || (rd_a == $past(wd)));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_datapath_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_we,
  input  logic            pc_we_cond,
  input  logic [1:0]      pc_src,
  input  logic            addr_sel,
  input  logic            ir_we,
  input  logic            rf_we,
  input  logic            wb_dst_sel,
  input  logic            wb_src_sel,
  input  logic            opa_sel,
  input  logic [1:0]      opb_sel,
  input  logic [1:0]      alu_mode,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            alu_zero
);
  localparam int IMM_W = 16;
  localparam int TGT_W = 26;

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alo_q;
  logic [XLEN-1:0] rf_a, rf_b, opa, opb, alu_y, pc_nxt, wb_data;
  logic [XLEN-1:0] imm_ext, imm_sh, jmp_tgt;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f, wb_addr;
  logic pc_load;
  alu_op_e op;

  assign rs_f = ir_q[25:21];
  assign rt_f = ir_q[20:16];
  assign rd_f = ir_q[15:11];

  assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh  = {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1:TGT_W+2], ir_q[TGT_W-1:0], 2'b00};

  assign opa = opa_sel ? a_q : pc_q;

  always_comb begin
    case (opb_sel)
      OPB_REG:   opb = b_q;
      OPB_FOUR:  opb = XLEN'(4);
      OPB_IMM:   opb = imm_ext;
      default:   opb = imm_sh;
    endcase
  end

  mc_alu_ctrl u_ctrl (
    .mode (alu_mode),
    .fn   (ir_q[5:0]),
    .op   (op)
  );

  mc_alu #(.W(XLEN)) u_alu (
    .x    (opa),
    .y    (opb),
    .op   (op),
    .res  (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    case (pc_src)
      PCS_LATCH: pc_nxt = alo_q;
      PCS_JUMP:  pc_nxt = jmp_tgt;
      default:   pc_nxt = alu_y;
    endcase
  end

  assign pc_load = pc_we | (pc_we_cond & alu_zero);
  assign wb_addr = wb_dst_sel ? rd_f : rt_f;
  assign wb_data = wb_src_sel ? mdr_q : alo_q;

  mc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_a  (rs_f),
    .ra_b  (rt_f),
    .rd_a  (rf_a),
    .rd_b  (rf_b),
    .we    (rf_we),
    .wa    (wb_addr),
    .wd    (wb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alo_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_nxt;
      if (ir_we)   ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      alo_q <= alu_y;
    end
  end

  assign mem_addr  = addr_sel ? alo_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  // PC holds when no write condition is met (R7)
  assert_pc_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !(pc_we_cond && alu_zero)) |=> $stable(pc_q));

  // jump keeps the top PC bits and word alignment (R8)
  assert_pc_jump_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == PCS_JUMP) |=>
      (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:TGT_W+2] == $past(pc_q[XLEN-1:TGT_W+2])));

  // instruction register holds without its enable (R3)
  assert_ir_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q));

  // reading register zero into latch A always gives zero (R10)
  assert_r0_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (rs_f == '0) |=> (a_q == '0));

  // result latch captures the live ALU result each cycle (R11)
  assert_alo_capture_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alo_q == $past(alu_y)));
endmodule

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_we, pc_we_cond, addr_sel, ir_we, rf_we, wb_dst_sel, wb_src_sel, opa_sel;
  logic [1:0] pc_src, opb_sel, alu_mode;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0] opcode, funct;
  logic alu_zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_alo;
  logic [31:0] m_rf [32];

  always #2.5 clk = ~clk;

  mc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .pc_src(pc_src), .addr_sel(addr_sel), .ir_we(ir_we), .rf_we(rf_we),
    .wb_dst_sel(wb_dst_sel), .wb_src_sel(wb_src_sel), .opa_sel(opa_sel),
    .opb_sel(opb_sel), .alu_mode(alu_mode), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode),
    .funct(funct), .alu_zero(alu_zero)
  );

  function automatic logic [31:0] alu_f(input logic [31:0] x, input logic [31:0] y,
                                        input logic [1:0] md, input logic [5:0] fn);
    if (md == 2'd1) return x - y;
    if (md != 2'd2) return x + y;
    case (fn)
      6'h22: return x - y;
      6'h24: return x & y;
      6'h25: return x | y;
      6'h2A: return {31'd0, ($signed(x) < $signed(y))};
      default: return x + y;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_we = 0; pc_we_cond = 0; pc_src = 0; addr_sel = 0; ir_we = 0; rf_we = 0;
    wb_dst_sel = 0; wb_src_sel = 0; opa_sel = 0; opb_sel = 0; alu_mode = 0;
    mem_rdata = 32'h0;
  endtask

  task automatic step(input string tag);
    logic [31:0] x, y, r, pn, imm, wd;
    logic [4:0] wa;
    #1;
    imm = {{16{m_ir[15]}}, m_ir[15:0]};
    x = opa_sel ? m_a : m_pc;
    case (opb_sel)
      2'd0: y = m_b;
      2'd1: y = 32'd4;
      2'd2: y = imm;
      default: y = imm << 2;
    endcase
    r = alu_f(x, y, alu_mode, m_ir[5:0]);
    check(mem_addr, addr_sel ? m_alo : m_pc, tag == "" ? (addr_sel ? "R2" : "R7") : tag);
    check(mem_wdata, m_b, tag == "" ? "R11" : tag);
    check({26'd0, opcode}, {26'd0, m_ir[31:26]}, tag == "" ? "R3" : tag);
    check({26'd0, funct}, {26'd0, m_ir[5:0]}, tag == "" ? "R3" : tag);
    check({31'd0, alu_zero}, {31'd0, (r == 32'd0)}, tag == "" ? "R5" : tag);
    case (pc_src)
      2'd1: pn = m_alo;
      2'd2: pn = {m_pc[31:28], m_ir[25:0], 2'b00};
      default: pn = r;
    endcase
    wa = wb_dst_sel ? m_ir[15:11] : m_ir[20:16];
    wd = wb_src_sel ? m_mdr : m_alo;
    @(posedge clk);
    if (pc_we || (pc_we_cond && r == 32'd0)) m_pc = pn;
    m_a = m_rf[m_ir[25:21]];
    m_b = m_rf[m_ir[20:16]];
    if (ir_we) m_ir = mem_rdata;
    m_mdr = mem_rdata;
    m_alo = r;
    if (rf_we && wa != 5'd0) m_rf[wa] = wd;
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [4:0] idx, input logic [31:0] val);
    idle(); mem_rdata = {11'd0, idx, 16'd0}; ir_we = 1; step("R9");
    idle(); mem_rdata = val; step("R9");
    idle(); rf_we = 1; wb_src_sel = 1; step("R9");
  endtask

  task automatic rtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                       input logic [5:0] fn, input string tag);
    idle(); mem_rdata = {6'd0, rs, rt, rd, 5'd0, fn}; ir_we = 1; step(tag);
    idle(); step(tag);
    idle(); opa_sel = 1; alu_mode = 2; step(tag);
    idle(); addr_sel = 1; rf_we = 1; wb_dst_sel = 1; step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle();
    m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_alo = 0;
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    #1;
    check(mem_addr, 32'd0, "R1");
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");

    // R6 / R10 / R9: register values through the memory data path
    write_reg(5'd1, 32'hFFFF_FFF0);
    write_reg(5'd2, 32'd5);
    rtype(5'd1, 5'd2, 5'd3, 6'h2A, "R6");
    rtype(5'd2, 5'd1, 5'd4, 6'h2A, "R6");
    rtype(5'd1, 5'd2, 5'd5, 6'h22, "R6");
    rtype(5'd1, 5'd2, 5'd6, 6'h24, "R6");
    rtype(5'd1, 5'd2, 5'd7, 6'h25, "R6");
    rtype(5'd1, 5'd2, 5'd8, 6'h3F, "R6");
    write_reg(5'd0, 32'h1234_5678);
    rtype(5'd0, 5'd0, 5'd9, 6'h20, "R10");

    // R4: operand selects, immediate with sign bit set
    idle(); mem_rdata = {6'h23, 5'd1, 5'd2, 16'h8001}; ir_we = 1; step("R4");
    for (int s = 0; s < 4; s++) begin
      idle(); opb_sel = 2'(s); opa_sel = s[0]; step("R4");
      idle(); addr_sel = 1; step("R4");
    end
    // R5: subtract mode
    idle(); opa_sel = 1; alu_mode = 1; step("R5");
    idle(); addr_sel = 1; step("R5");

    // R8: jump and latch source
    idle(); mem_rdata = {6'h02, 26'h3AB_CDEF}; ir_we = 1; step("R8");
    idle(); pc_we = 1; pc_src = 2; step("R8");
    idle(); step("R8");
    idle(); opb_sel = 1; step("R8");
    idle(); pc_we = 1; pc_src = 1; step("R8");
    idle(); pc_we = 1; pc_src = 3; opb_sel = 1; step("R8");
    idle(); step("R8");

    // R7: conditional PC write, taken then untaken
    rtype(5'd2, 5'd2, 5'd10, 6'h20, "R7");
    idle(); opb_sel = 3; step("R7");
    idle(); opa_sel = 1; alu_mode = 1; pc_we_cond = 1; pc_src = 1; step("R7");
    idle(); step("R7");
    rtype(5'd1, 5'd2, 5'd11, 6'h20, "R7");
    idle(); opa_sel = 1; alu_mode = 1; pc_we_cond = 1; pc_src = 1; step("R7");
    idle(); step("R7");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] c;
      logic [5:0] fns [5];
      fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
      c = $urandom;
      pc_we = (c[2:0] == 3'd0); pc_we_cond = c[3]; pc_src = c[5:4];
      addr_sel = c[6]; ir_we = (c[9:7] < 3'd3); rf_we = c[10];
      wb_dst_sel = c[11]; wb_src_sel = c[12]; opa_sel = c[13];
      opb_sel = c[15:14]; alu_mode = c[17:16];
      mem_rdata = $urandom;
      if (c[18]) mem_rdata[5:0] = fns[$urandom % 5];
      step("");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule